// File: doc/BRIEF.md
# Serial Mitchell Antilogarithm Unit

This unit approximates 2^x for a strictly negative fixed-point two's-complement value x. It uses Mitchell's piecewise-linear rule, 2^int(x)·(1+frac(x)). The operand arrives one bit per clock, least significant bit first, and has FRAC_W fractional bits and INT_W integer bits. A framing input, `sync_i`, separates three groups of bits:

- the fraction bits;
- the low-order integer bits that select the shift distance;
- the high-order integer bits that can only signal underflow.

The block builds 1.frac in a working register. Each low-order integer bit that is 0 shifts the register right by a power of two, and one more single-position shift is applied when the frame ends. A 0 in any high-order integer bit forces the result to zero.

The block is pipelined. When a frame completes, the result is latched into a parallel output and a one-cycle pulse is raised. For the following FRAC_W+1 cycles the same value is streamed out LSB first under a mask strobe, while the next operand is already arriving.

The bit stream runs freely and has no back-pressure. There is no valid/ready pair: every clock carries exactly one operand bit, and the sender must keep frames contiguous. A downstream consumer must take the serial output in the masked cycles, or take the parallel output at any time before the next pulse.

Top module: `mitch_antilog`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `res_o` is 0 and `mask_o`, `pulse_o` and `sout_o` are 0.
- R2: A frame is INT_W+FRAC_W bits, LSB first. `sync_i` is 1 for the FRAC_W fraction bits, then 0 for L = ceil(log2 FRAC_W) low-order integer bits, then 1 for the remaining INT_W−L integer bits. Frames follow each other with no gap. The first frame starts at the first cycle with `sync_i` = 1 after reset, and while idle with `sync_i` = 0 the data input has no effect on any output.
- R3: For a strictly negative operand x, the result is floor(2^FRAC_W · 2^int(x) · (1+frac(x))), given as a FRAC_W+1 bit unsigned integer in units of 2^−FRAC_W. Here int(x) = floor(x), and the shift distance is −int(x).
- R4: If any integer bit at position L or above is 0, so that the shift distance exceeds 2^L, the result is exactly 0.
- R5: `res_o` changes only in the cycle after the last bit of a frame, and holds its value for the rest of the time.
- R6: `pulse_o` is 1 for exactly one cycle: the cycle after each frame's last bit.
- R7: `mask_o` is 1 for exactly FRAC_W+1 consecutive cycles, starting in the pulse cycle.
- R8: In the j-th masked cycle (j = 0..FRAC_W), `sout_o` equals bit j of the new `res_o`. Outside the mask, `sout_o` is 0.
- R9: Bit FRAC_W of `res_o` is always 0, so the result is below 1.0.
- R10: The bits of the next frame are accepted in the same cycles in which the previous result is streamed out, and both are correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Field framing strobe |
| din_i | input | 1 | Serial operand bit, LSB first |
| res_o | output | FRAC_W+1 | Parallel result of the last completed frame |
| sout_o | output | 1 | Serial result, LSB first, zero outside mask |
| mask_o | output | 1 | Marks the FRAC_W+1 cycles of serial result |
| pulse_o | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The assertions take for granted that `sync_i` follows the frame pattern exactly: low in every low-order integer cycle, and high in every high-order scan cycle. They also assume that operands are strictly negative, because a zero operand would decode as a maximal shift and give an underflow result. The bench derives `sync_i` from a bit-position counter, so framing is correct by construction. It sweeps every strictly negative operand of a 6-integer, 8-fraction configuration in back-to-back frames.

// File: rtl/malog_pkg.sv
package malog_pkg;
  // one-hot control phases
  typedef enum logic [3:0] {
    ST_IDLE = 4'b0001,
    ST_FRAC = 4'b0010,
    ST_LOW  = 4'b0100,
    ST_HIGH = 4'b1000
  } phase_e;
endpackage

// File: rtl/mitch_ctrl.sv
module mitch_ctrl #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 6,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              din_i,
  output logic              cap_o,
  output logic              shr_o,
  output logic [CW-1:0]     idx_o,
  output logic              scan_o,
  output logic              done_o,
  output malog_pkg::phase_e phase_o
);
  import malog_pkg::*;

  localparam int LOW_N  = $clog2(FRAC_W);
  localparam int HIGH_N = INT_W - LOW_N;
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_N - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_N - 1);

  phase_e        st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    cap_o  = 1'b0;
    shr_o  = 1'b0;
    idx_o  = '0;
    scan_o = 1'b0;
    done_o = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (sync_i) begin
          cap_o = 1'b1;
          st_n  = ST_FRAC;
        end
      end
      ST_FRAC: begin
        if (sync_i) begin
          cap_o = 1'b1;
        end else begin
          // integer bit 0 arrives as sync drops
          shr_o = !din_i;
          idx_o = '0;
          if (LOW_N == 1) begin
            st_n  = ST_HIGH;
            cnt_n = '0;
          end else begin
            st_n  = ST_LOW;
            cnt_n = CW'(1);
          end
        end
      end
      ST_LOW: begin
        shr_o = !din_i;
        idx_o = cnt;
        if (cnt == LOW_LAST) begin
          st_n  = ST_HIGH;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
      ST_HIGH: begin
        scan_o = 1'b1;
        if (cnt == HIGH_LAST) begin
          done_o = 1'b1;
          st_n   = ST_FRAC;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign phase_o = st;
endmodule

// File: rtl/mitch_core.sv
module mitch_core #(
  parameter int FRAC_W = 8,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_i,
  input  logic              cap_i,
  input  logic              shr_i,
  input  logic [CW-1:0]     idx_i,
  input  logic              scan_i,
  input  logic              done_i,
  output logic [FRAC_W:0]   fin_o
);
  localparam int LOW_N = $clog2(FRAC_W);
  localparam int RW    = FRAC_W + 1;

  logic [RW-1:0] work;
  logic [RW-1:0] shv [LOW_N];
  logic [RW-1:0] shifted;
  logic          zap;

  // one precomputed right shift per power-of-two step
  for (genvar g = 0; g < LOW_N; g++) begin : g_step
    assign shv[g] = work >> (1 << g);
  end

  always_comb begin
    shifted = work;
    for (int g = 0; g < LOW_N; g++) begin
      if (idx_i == CW'(g)) shifted = shv[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
      zap  <= 1'b0;
    end else begin
      if (cap_i)      work <= {1'b1, din_i, work[FRAC_W-1:1]};
      else if (shr_i) work <= shifted;
      if (done_i)               zap <= 1'b0;
      else if (scan_i && !din_i) zap <= 1'b1;
    end
  end

  // final single-step shift, or underflow to zero
  assign fin_o = (zap || !din_i) ? '0 : (work >> 1);
endmodule

// File: rtl/mitch_emit.sv
module mitch_emit #(
  parameter int FRAC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [FRAC_W:0] val_i,
  output logic [FRAC_W:0] res_o,
  output logic            sout_o,
  output logic            mask_o,
  output logic            pulse_o
);
  localparam int MW = $clog2(FRAC_W + 2);
  localparam logic [MW-1:0] WIN = MW'(FRAC_W + 1);

  logic [FRAC_W:0] sh;
  logic [MW-1:0]   mcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      sh      <= '0;
      mcnt    <= '0;
      pulse_o <= 1'b0;
    end else if (load_i) begin
      res_o   <= val_i;
      sh      <= val_i;
      mcnt    <= WIN;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
      if (mcnt != '0) begin
        mcnt <= mcnt - MW'(1);
        sh   <= sh >> 1;
      end
    end
  end

  assign mask_o = (mcnt != '0);
  assign sout_o = mask_o & sh[0];
endmodule

// File: rtl/mitch_antilog.sv
module mitch_antilog #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic            din_i,
  output logic [FRAC_W:0] res_o,
  output logic            sout_o,
  output logic            mask_o,
  output logic            pulse_o
);
  localparam int CW = $clog2(INT_W);

  logic              cap, shr, scan, done;
  logic [CW-1:0]     idx;
  logic [FRAC_W:0]   fin;
  malog_pkg::phase_e phase;

  mitch_ctrl #(.FRAC_W(FRAC_W), .INT_W(INT_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .din_i(din_i),
    .cap_o(cap), .shr_o(shr), .idx_o(idx), .scan_o(scan),
    .done_o(done), .phase_o(phase)
  );

  mitch_core #(.FRAC_W(FRAC_W), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .din_i(din_i), .cap_i(cap), .shr_i(shr),
    .idx_i(idx), .scan_i(scan), .done_i(done), .fin_o(fin)
  );

  mitch_emit #(.FRAC_W(FRAC_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .load_i(done), .val_i(fin),
    .res_o(res_o), .sout_o(sout_o), .mask_o(mask_o), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/mitch_antilog_chk.sv
module mitch_antilog_chk #(
  parameter int FRAC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_i,
  input logic [3:0]      phase_i,
  input logic [FRAC_W:0] res_i,
  input logic            sout_i,
  input logic            mask_i,
  input logic            pulse_i
);
  AST_LOW_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 4'b0100) |-> !sync_i); // R2
  AST_SCAN_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 4'b1000) |-> sync_i); // R2
  AST_RES_ONLY_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_i != $past(res_i)) |-> pulse_i); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> !pulse_i); // R6
  AST_PULSE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |-> mask_i); // R7
  AST_MASK_STARTS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_i) |-> pulse_i); // R7
  AST_FIRST_SERIAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |-> (sout_i == res_i[0])); // R8
  AST_BELOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_i[FRAC_W]); // R9
endmodule

bind mitch_antilog mitch_antilog_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .phase_i(phase),
  .res_i(res_o), .sout_i(sout_o), .mask_i(mask_o), .pulse_i(pulse_o)
);

// File: tb/mitch_antilog_tb.sv
module mitch_antilog_tb;
  localparam int F  = 8;
  localparam int K  = 6;
  localparam int L  = $clog2(F);
  localparam int FL = K + F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_i = 1'b0;
  logic         din_i = 1'b0;
  logic [F:0]   res_o;
  logic         sout_o, mask_o, pulse_o;

  int nchk = 0;
  int nfail = 0;
  int prev_exp = 0;
  bit have_prev = 1'b0;

  always #5 clk = ~clk;

  mitch_antilog #(.FRAC_W(F), .INT_W(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .din_i(din_i),
    .res_o(res_o), .sout_o(sout_o), .mask_o(mask_o), .pulse_o(pulse_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 / R4 reference: floor((2^F + frac) * 2^int)
  function automatic int ref_val(input int v);
    int ip, fr, sh;
    ip = v >>> F;
    fr = v & ((1 << F) - 1);
    sh = -ip;
    if (sh > F + 1) return 0;
    return ((1 << F) + fr) >> sh;
  endfunction

  task automatic sample(input int p);
    if (!have_prev) begin
      chk("R1 res", int'(res_o), 0);
      chk("R1 mask", int'(mask_o), 0);
      chk("R1 pulse", int'(pulse_o), 0);
      chk("R1 sout", int'(sout_o), 0);
    end else begin
      if (p == 0) begin
        chk("R6 pulse", int'(pulse_o), 1);
        chk(prev_exp == 0 ? "R4 underflow" : "R3 result", int'(res_o), prev_exp);
        chk("R10 overlap", int'(sout_o), prev_exp & 1);
      end else begin
        chk("R6 pulse low", int'(pulse_o), 0);
        chk("R5 hold", int'(res_o), prev_exp);
      end
      if (p <= F) begin
        chk("R7 mask", int'(mask_o), 1);
        chk("R8 sout", int'(sout_o), (prev_exp >> p) & 1);
      end else begin
        chk("R7 mask low", int'(mask_o), 0);
        chk("R8 sout quiet", int'(sout_o), 0);
      end
      chk("R9 top bit", int'(res_o[F]), 0);
    end
  endtask

  task automatic run_frame(input int v);
    for (int p = 0; p < FL; p++) begin
      @(negedge clk);
      sample(p);
      sync_i = (p < F) ? 1'b1 : ((p < F + L) ? 1'b0 : 1'b1);
      din_i  = 1'((v >> p) & 1);
    end
    prev_exp  = ref_val(v);
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sample(0); // R1 during reset
    rst_n = 1'b1;
    // R2: idle with sync low, data toggling, must not start a frame
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sample(0);
      din_i = 1'(i & 1);
    end
    for (int v = -1; v >= -(1 << (FL - 1)); v--) run_frame(v);
    run_frame(-1); // flush the final result
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule